// File: doc/BRIEF.md
# Chained Block Descriptor Loader

This unit controls one DMA channel that runs a chain of blocks without processor help. Before each block, it reads a five-word descriptor from memory and writes it into the channel's working registers. These registers are the source address, the destination address, the next-descriptor pointer and a 64-bit control value. It then tells a block engine to start. When the engine reports that the block is finished, the unit decides whether to fetch another descriptor or to end the transfer.

Software prepares the first transfer while the channel is idle. It writes the address of the first descriptor into the next-pointer register and writes the low control word with one or both chaining enable bits set. Descriptors are read through a simple word-read master. The read address and request are held until a valid response returns, and one word is accepted for each valid response. The block engine that moves the data is outside this unit. It is reached through a start pulse and a done input.

Top module: `blk_chain_loader`

## Requirements
- R1: After reset, the unit is idle. `busy`, `rd_req`, `blk_start` and `xfer_done` are low, and all four channel registers read zero.
- R2: A write with select code 1 (low control word) while idle stores the data into `ctl_word[31:0]`. If data bit 27 (source chaining) or bit 28 (destination chaining) is set, `busy` rises in the next cycle and a fetch begins at `next_ptr`. If neither bit is set, the unit stays idle.
- R3: During a fetch, `rd_req` stays high. `rd_addr` steps through base, base+4, base+8, base+12 and base+16. The address advances only in a cycle where `rd_rvalid` is high.
- R4: The five descriptor words are, in order: source address, destination address, next pointer, control low, control high. The channel registers keep their values while words arrive. All of them change together on the clock edge that accepts the fifth word.
- R5: `blk_start` is high for exactly the one cycle after the fifth word is accepted. The block then lasts until `blk_done` is sampled high. `blk_done` has no effect at any other time.
- R6: The cycle after `blk_done` is a decision cycle. If the loaded next pointer is non-zero and bit 27 or bit 28 of the loaded control value is set, a new fetch starts at that pointer. Otherwise `xfer_done` is high for one cycle while the unit returns to idle.
- R7: While `busy` is high, register writes of every select code are ignored.
- R8: `next_ptr` always has bits 1:0 cleared. This holds both for a write with select code 0 and for a pointer loaded from a descriptor.
- R9: A write with select code 2 while idle stores the data into `ctl_word[63:32]` and does not start a fetch. Select code 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 2 | Register select: 0 next pointer, 1 control low, 2 control high |
| cfg_wr_data | input | 32 | Register write data |
| rd_req | output | 1 | Descriptor read request, held until a response |
| rd_addr | output | 32 | Descriptor word address |
| rd_rvalid | input | 1 | Read response valid |
| rd_rdata | input | 32 | Read response data |
| blk_start | output | 1 | One-cycle pulse: block engine may start |
| blk_done | input | 1 | Block engine finished the current block |
| xfer_done | output | 1 | One-cycle pulse: chain finished |
| busy | output | 1 | Channel is not idle |
| src_addr | output | 32 | Loaded source address |
| dst_addr | output | 32 | Loaded destination address |
| next_ptr | output | 32 | Address of the next descriptor |
| ctl_word | output | 64 | Loaded control value |

## Verification
| Result | When it is due | Observed at |
|---|---|---|
| `busy` rise | one cycle after the starting write | following falling edge |
| `rd_addr` advance | one cycle after each accepted word | following falling edge |
| Register update and `blk_start` pulse | cycle after the fifth accepted word | following falling edge |
| Decision cycle | cycle after `blk_done` is sampled | following falling edge |
| `xfer_done` (or `rd_req` back high) | one cycle after the decision cycle | following falling edge |

The bench keeps a behavioural model that is advanced on the same rising edge as the design, using only the inputs the bench itself drives. Every output is compared with that model at the following falling edge, so each of the timings above is checked in the exact cycle it is due. Memory latency and engine delay are varied, and this moves every one of those cycles.

// File: rtl/bcl_pkg.sv
package bcl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_RUN   = 2'd2,
    ST_CHECK = 2'd3
  } bcl_state_e;

  localparam logic [1:0] SEL_NEXT   = 2'd0;
  localparam logic [1:0] SEL_CTL_LO = 2'd1;
  localparam logic [1:0] SEL_CTL_HI = 2'd2;

  // Word positions inside one descriptor.
  localparam int DW_SRC    = 0;
  localparam int DW_DST    = 1;
  localparam int DW_NEXT   = 2;
  localparam int DW_CTL_LO = 3;
  localparam int DW_CTL_HI = 4;
  localparam int DESC_WORDS = 5;

  function automatic logic [31:0] align_word(input logic [31:0] a);
    return {a[31:2], 2'b00};
  endfunction

  function automatic logic chain_enabled(input logic [31:0] ctl_lo,
                                         input int src_bit, input int dst_bit);
    return ctl_lo[src_bit] | ctl_lo[dst_bit];
  endfunction
endpackage

// File: rtl/bcl_desc_reader.sv
module bcl_desc_reader #(
  parameter int W     = 32,
  parameter int WORDS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [W-1:0]     base,
  input  logic             rvalid,
  input  logic [W-1:0]     rdata,
  output logic             req,
  output logic [W-1:0]     addr,
  output logic             last_acc,
  output logic [WORDS*W-1:0] words
);
  localparam int IDX_W = $clog2(WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  logic             active;
  logic [IDX_W-1:0] idx;
  logic [W-1:0]     held [WORDS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
    end else if (go) begin
      active <= 1'b1;
      idx    <= '0;
    end else if (active && rvalid) begin
      if (idx == LAST_IDX) active <= 1'b0;
      else                 idx    <= idx + 1'b1;
    end
  end

  for (genvar i = 0; i < WORDS - 1; i++) begin : g_hold
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     held[i] <= '0;
      else if (active && rvalid && idx == IDX_W'(i))  held[i] <= rdata;
    end
    assign words[i*W +: W] = held[i];
  end
  // The final word is taken straight from the response bus.
  assign words[(WORDS-1)*W +: W] = rdata;

  assign req      = active;
  assign addr     = base + (W'(idx) << 2);
  assign last_acc = active && rvalid && (idx == LAST_IDX);
endmodule

// File: rtl/bcl_seq_fsm.sv
module bcl_seq_fsm
  import bcl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_req,
  input  logic       last_acc,
  input  logic       blk_done,
  input  logic       cont,
  output bcl_state_e state,
  output logic       fetch_go,
  output logic       blk_start,
  output logic       xfer_done
);
  bcl_state_e nxt_state;

  always_comb begin
    nxt_state = state;
    fetch_go  = 1'b0;
    unique case (state)
      ST_IDLE:  if (start_req) begin nxt_state = ST_FETCH; fetch_go = 1'b1; end
      ST_FETCH: if (last_acc) nxt_state = ST_RUN;
      ST_RUN:   if (blk_done) nxt_state = ST_CHECK;
      ST_CHECK: begin
        if (cont) begin nxt_state = ST_FETCH; fetch_go = 1'b1; end
        else           nxt_state = ST_IDLE;
      end
      default:  nxt_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      blk_start <= 1'b0;
      xfer_done <= 1'b0;
    end else begin
      state     <= nxt_state;
      blk_start <= (state == ST_FETCH) && last_acc;
      xfer_done <= (state == ST_CHECK) && !cont;
    end
  end
endmodule

// File: rtl/blk_chain_loader.sv
module blk_chain_loader
  import bcl_pkg::*;
#(
  parameter int W       = 32,
  parameter int SRC_BIT = 27,
  parameter int DST_BIT = 28
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr_en,
  input  logic [1:0]     cfg_wr_sel,
  input  logic [W-1:0]   cfg_wr_data,
  output logic           rd_req,
  output logic [W-1:0]   rd_addr,
  input  logic           rd_rvalid,
  input  logic [W-1:0]   rd_rdata,
  output logic           blk_start,
  input  logic           blk_done,
  output logic           xfer_done,
  output logic           busy,
  output logic [W-1:0]   src_addr,
  output logic [W-1:0]   dst_addr,
  output logic [W-1:0]   next_ptr,
  output logic [2*W-1:0] ctl_word
);
  bcl_state_e            state;
  logic                  idle, start_req, cont, fetch_go, load_evt;
  logic [DESC_WORDS*W-1:0] words;
  logic                  wr_next, wr_lo, wr_hi;

  assign idle      = (state == ST_IDLE);
  assign busy      = !idle;
  assign wr_next   = idle && cfg_wr_en && (cfg_wr_sel == SEL_NEXT);
  assign wr_lo     = idle && cfg_wr_en && (cfg_wr_sel == SEL_CTL_LO);
  assign wr_hi     = idle && cfg_wr_en && (cfg_wr_sel == SEL_CTL_HI);
  assign start_req = wr_lo && chain_enabled(cfg_wr_data, SRC_BIT, DST_BIT);
  assign cont      = (next_ptr != '0) && chain_enabled(ctl_word[W-1:0], SRC_BIT, DST_BIT);

  bcl_desc_reader #(.W(W), .WORDS(DESC_WORDS)) u_reader (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (fetch_go),
    .base     (next_ptr),
    .rvalid   (rd_rvalid),
    .rdata    (rd_rdata),
    .req      (rd_req),
    .addr     (rd_addr),
    .last_acc (load_evt),
    .words    (words)
  );

  bcl_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .last_acc  (load_evt),
    .blk_done  (blk_done),
    .cont      (cont),
    .state     (state),
    .fetch_go  (fetch_go),
    .blk_start (blk_start),
    .xfer_done (xfer_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_addr <= '0;
      dst_addr <= '0;
      next_ptr <= '0;
      ctl_word <= '0;
    end else if (load_evt) begin
      src_addr <= words[DW_SRC*W +: W];
      dst_addr <= words[DW_DST*W +: W];
      next_ptr <= align_word(words[DW_NEXT*W +: W]);
      ctl_word <= {words[DW_CTL_HI*W +: W], words[DW_CTL_LO*W +: W]};
    end else begin
      if (wr_next) next_ptr <= align_word(cfg_wr_data);
      if (wr_lo)   ctl_word[W-1:0] <= cfg_wr_data;
      if (wr_hi)   ctl_word[2*W-1:W] <= cfg_wr_data;
    end
  end
endmodule

// File: rtl/bcl_chain_checker.sv
module bcl_chain_checker #(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_wr_en,
  input logic           rd_req,
  input logic           blk_start,
  input logic           xfer_done,
  input logic           busy,
  input logic           load_evt,
  input logic [W-1:0]   src_addr,
  input logic [W-1:0]   next_ptr,
  input logic [2*W-1:0] ctl_word
);
  p_req_needs_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> busy);

  p_regs_hold_in_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !load_evt) |=> ($stable(src_addr) && $stable(ctl_word) && $stable(next_ptr)));

  p_load_kicks_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> blk_start);

  p_start_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start |=> !blk_start);

  p_done_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !busy);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  p_busy_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_wr_en && !load_evt) |=> ($stable(ctl_word) && $stable(next_ptr)));

  p_ptr_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
    next_ptr[1:0] == 2'b00);
endmodule

bind blk_chain_loader bcl_chain_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_wr_en (cfg_wr_en),
  .rd_req    (rd_req),
  .blk_start (blk_start),
  .xfer_done (xfer_done),
  .busy      (busy),
  .load_evt  (load_evt),
  .src_addr  (src_addr),
  .next_ptr  (next_ptr),
  .ctl_word  (ctl_word)
);

// File: tb/blk_chain_loader_tb.sv
module blk_chain_loader_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [1:0]  cfg_wr_sel = 2'd0;
  logic [31:0] cfg_wr_data = '0;
  logic        rd_req, blk_start, xfer_done, busy;
  logic [31:0] rd_addr, src_addr, dst_addr, next_ptr;
  logic [63:0] ctl_word;
  logic        rd_rvalid = 1'b0;
  logic [31:0] rd_rdata = '0;
  logic        eng_done = 1'b0, stray_done = 1'b0;
  wire         blk_done = eng_done | stray_done;

  blk_chain_loader u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
    .cfg_wr_data(cfg_wr_data), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata), .blk_start(blk_start),
    .blk_done(blk_done), .xfer_done(xfer_done), .busy(busy),
    .src_addr(src_addr), .dst_addr(dst_addr), .next_ptr(next_ptr),
    .ctl_word(ctl_word)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int mem_lat = 0, eng_dly = 2, lat_cnt = 0, eng_cnt = 0;
  bit eng_on = 0;
  logic [31:0] mem [logic [31:0]];

  // Behavioural reference: phase 0 idle, 1 reading, 2 block, 3 deciding.
  int          m_ph = 0, m_k = 0;
  logic [31:0] m_w [5];
  logic [31:0] m_src = 0, m_dst = 0, m_nxt = 0;
  logic [63:0] m_ctl = 0;
  bit          m_bs = 0, m_xd = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_k = 0; m_src = 0; m_dst = 0; m_nxt = 0; m_ctl = 0; m_bs = 0; m_xd = 0;
    end else begin
      m_bs = 0; m_xd = 0;
      case (m_ph)
        0: if (cfg_wr_en) begin
             if (cfg_wr_sel == 2'd0) m_nxt = cfg_wr_data & 32'hFFFF_FFFC;
             else if (cfg_wr_sel == 2'd1) begin
               m_ctl[31:0] = cfg_wr_data;
               if (cfg_wr_data[27] || cfg_wr_data[28]) begin m_ph = 1; m_k = 0; end
             end else if (cfg_wr_sel == 2'd2) m_ctl[63:32] = cfg_wr_data;
           end
        1: if (rd_rvalid) begin
             m_w[m_k] = rd_rdata;
             if (m_k == 4) begin
               m_src = m_w[0]; m_dst = m_w[1]; m_nxt = m_w[2] & 32'hFFFF_FFFC;
               m_ctl = {m_w[4], m_w[3]}; m_ph = 2; m_bs = 1;
             end else m_k++;
           end
        2: if (blk_done) m_ph = 3;
        default: begin
          if (m_nxt != 0 && (m_ctl[27] || m_ctl[28])) begin m_ph = 1; m_k = 0; end
          else begin m_ph = 0; m_xd = 1; end
        end
      endcase
    end
  end

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Per-cycle comparison, then memory and engine responses.
  always @(negedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <%0d cycles", cyc, WATCHDOG);
      finish_run();
    end
    if (rst_n) begin
      check("R2", "busy", busy, m_ph != 0);
      check("R3", "rd_req", rd_req, m_ph == 1);
      if (m_ph == 1) check("R3", "rd_addr", rd_addr, m_nxt + 32'(m_k * 4));
      check("R4", "src_addr", src_addr, m_src);
      check("R4", "dst_addr", dst_addr, m_dst);
      check("R8", "next_ptr", next_ptr, m_nxt);
      check("R4", "ctl_word", ctl_word, m_ctl);
      check("R5", "blk_start", blk_start, m_bs);
      check("R6", "xfer_done", xfer_done, m_xd);
    end
    if (rd_req) begin
      if (lat_cnt >= mem_lat) begin
        rd_rvalid = 1'b1;
        rd_rdata  = mem.exists(rd_addr) ? mem[rd_addr] : 32'h0;
        lat_cnt   = 0;
      end else begin
        rd_rvalid = 1'b0; lat_cnt++;
      end
    end else begin
      rd_rvalid = 1'b0; lat_cnt = 0;
    end
    if (blk_start) begin eng_on = 1; eng_cnt = eng_dly; end
    if (eng_on && eng_cnt == 0) begin eng_done = 1'b1; eng_on = 0; end
    else begin eng_done = 1'b0; if (eng_on) eng_cnt--; end
  end

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic put_desc(input logic [31:0] base, input logic [31:0] s, input logic [31:0] d,
                          input logic [31:0] n, input logic [31:0] lo, input logic [31:0] hi);
    mem[base] = s; mem[base+4] = d; mem[base+8] = n; mem[base+12] = lo; mem[base+16] = hi;
  endtask

  task automatic wait_done(output int blocks);
    blocks = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      #1;
      if (blk_start) blocks++;
      if (xfer_done) return;
    end
  endtask

  initial begin
    int nb;
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1", "busy", busy, 0);
    check("R1", "rd_req", rd_req, 0);
    check("R1", "blk_start", blk_start, 0);
    check("R1", "xfer_done", xfer_done, 0);
    check("R1", "regs", {src_addr, dst_addr} | {next_ptr, 32'h0} | ctl_word, 64'h0);
    rst_n = 1'b1;

    // R8: pointer write drops the low two bits
    wr(2'd0, 32'h0000_0103);
    check("R8", "next_ptr after write", next_ptr, 32'h0000_0100);
    // R9: high control word, and select 3 changes nothing
    wr(2'd2, 32'hA5A5_0001);
    check("R9", "ctl high", ctl_word[63:32], 32'hA5A5_0001);
    wr(2'd3, 32'hFFFF_FFFF);
    check("R9", "sel3 ctl", ctl_word, 64'hA5A5_0001_0000_0000);
    check("R9", "sel3 ptr", next_ptr, 32'h0000_0100);
    // R2: low control word without enable bits stays idle
    wr(2'd1, 32'h0000_00FF);
    check("R2", "ctl low stored", ctl_word[31:0], 32'h0000_00FF);
    check("R2", "idle without enable", busy, 0);
    // R5: stray done while idle has no effect
    @(negedge clk); stray_done = 1'b1; @(negedge clk); stray_done = 1'b0;
    check("R5", "stray done busy", busy, 0);
    check("R5", "stray done xfer_done", xfer_done, 0);

    // Chain of three: third block ends because its enable bits are clear (R6)
    put_desc(32'h100, 32'h1000, 32'h2000, 32'h200, 32'h0800_0011, 32'h0000_0040);
    put_desc(32'h200, 32'h1100, 32'h2100, 32'h30E, 32'h1000_0022, 32'h0000_0041);
    put_desc(32'h30C, 32'h1200, 32'h2200, 32'h400, 32'h0000_0033, 32'h0000_0042);
    mem_lat = 1; eng_dly = 3;
    fork
      begin
        wr(2'd1, 32'h1800_0000);
        wait_done(nb);
      end
      begin
        // R7: writes while the last block runs are ignored
        repeat (3) @(posedge blk_start);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = 2'd1; cfg_wr_data = 32'h1800_FFFF;
        @(negedge clk); cfg_wr_sel = 2'd0; cfg_wr_data = 32'h0000_0AAC;
        @(negedge clk); cfg_wr_en = 1'b0;
      end
    join
    check("R6", "blocks in chain", nb, 3);
    check("R7", "ctl after busy writes", ctl_word, 64'h0000_0042_0000_0033);
    check("R7", "ptr after busy writes", next_ptr, 32'h0000_0400);
    check("R4", "last src", src_addr, 32'h1200);
    check("R8", "loaded ptr aligned", next_ptr[1:0], 0);

    // Single block with zero next pointer ends (R6), zero latency
    put_desc(32'h500, 32'h3000, 32'h4000, 32'h0, 32'h1800_0001, 32'h0);
    mem_lat = 0; eng_dly = 0;
    wr(2'd0, 32'h500);
    wr(2'd1, 32'h0800_0000);
    wait_done(nb);
    check("R6", "zero pointer ends", nb, 1);
    check("R4", "dst loaded", dst_addr, 32'h4000);
    @(negedge clk);
    check("R6", "idle after done", busy, 0);

    // Destination bit alone starts, slow memory (R2, R3)
    put_desc(32'h600, 32'h5000, 32'h6000, 32'h0, 32'h0, 32'h7);
    mem_lat = 3; eng_dly = 1;
    wr(2'd0, 32'h600);
    wr(2'd1, 32'h1000_0000);
    wait_done(nb);
    check("R2", "dst-only start", nb, 1);
    check("R4", "ctl hi loaded", ctl_word[63:32], 32'h7);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule